// File: doc/BRIEF.md
# Scratchpad Line Protector with Cache-Held Dirty Copies

This controller guards a read/write scratchpad holding dynamically mapped code and data. The scratchpad is split into four-word lines, and each word carries an even parity bit. While a line is clean, main memory already holds a valid copy of it. When a store first modifies a line, the controller takes one of a small pool of reserved cache-array slots and writes the whole updated line there. Later stores to that line update only the written word in the slot. The backup store therefore grows and shrinks with the set of modified lines, instead of mirroring the whole scratchpad.

On every load, store or flush, the controller checks the parity of all four words of the addressed line. If any word is bad, the access stalls while the whole line is rebuilt. A dirty line is rebuilt from its cache slot and a clean line from main memory. The original access then completes. A flush writes a dirty line back to memory and returns its slot to the pool. When no slot is free, a store to a clean line writes its word through to memory, so the line stays clean. Two counters report how many restores came from each source.

Top module: `spm_guard`

## Requirements
- R1: After reset `ready` is 1, `done` is 0, both recovery counters are 0, every line is clean and every backup slot is free.
- R2: A load accepted while `ready` is 1 produces a single-cycle `done` pulse, with the stored word on `rdata` in that cycle. `ready` drops in the cycle after acceptance.
- R3: A store to a clean line while a slot is free takes the lowest-numbered free slot. The whole updated line is copied into it, with line word w at cache address (slot, w). The line becomes dirty.
- R4: A store to a dirty line writes only that word into the line's slot, at (slot, word), and causes no memory traffic.
- R5: A store to a clean line while no slot is free writes that word to memory at (line, word). The line stays clean, and a backup write and a memory request never occur together.
- R6: Parity is even per word. A parity error in any word of the addressed line triggers a restore of all four words before the access is performed.
- R7: A restore of a dirty line reads its four words from the line's cache slot and increments `rec_cache_cnt` by one.
- R8: A restore of a clean line reads its four words from memory and increments `rec_mem_cnt` by one. Only one counter steps per restore.
- R9: Flushing a dirty line writes its four current words to memory at (line, 0..3). The line is left clean and its slot is freed for reuse.
- R10: Flushing a clean line completes with a `done` pulse and no memory traffic.
- R11: A memory request keeps `mem_req`, `mem_we`, `mem_line` and `mem_word` steady until `mem_ack`.
- R12: A store that finds a parity error in its line is applied after the restore, so the restored words and the new word are all readable afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Load/store request, taken when `ready` |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | LW+2 | Line index and word offset (low two bits) |
| req_wdata | input | W | Store data |
| flush_req | input | 1 | Flush request, taken when `ready` and no `req` |
| flush_line | input | LW | Line to flush |
| ready | output | 1 | Controller idle, can accept |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | W | Load data, valid with `done` |
| cache_we | output | 1 | Write to the backup slot word |
| cache_slot | output | SW | Backup slot address |
| cache_word | output | 2 | Word within slot |
| cache_wdata | output | W | Backup write data |
| cache_rdata | input | W | Backup read data for (slot, word), same cycle |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = memory write |
| mem_line | output | LW | Memory line address |
| mem_word | output | 2 | Word within line |
| mem_wdata | output | W | Memory write data |
| mem_rdata | input | W | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory completes current word |
| inj_en | input | 1 | Flip one stored bit (fault injection) |
| inj_addr | input | LW+2 | Word to corrupt |
| inj_bit | input | $clog2(W) | Bit to flip |
| rec_cache_cnt | output | CNT_W | Restores served from cache |
| rec_mem_cnt | output | CNT_W | Restores served from memory |

## Verification
The bench builds the block with four lines, 16-bit words and only two backup slots. With so few slots, a third modified line exhausts the pool and forces the write-through path. A flush then frees a slot, and the bench shows it being taken again by a different line. Corruptions are placed in the word being accessed and in a neighbouring word of the same line, on dirty and on clean lines, and once ahead of a store. This covers both restore sources and the restore-then-store ordering.

// File: rtl/spm_guard.sv
module spm_guard #(
  parameter int LINES = 16,
  parameter int W     = 32,
  parameter int SLOTS = 4,
  parameter int CNT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req,
  input  logic                  req_we,
  input  logic [$clog2(LINES)+1:0] req_addr,
  input  logic [W-1:0]          req_wdata,
  input  logic                  flush_req,
  input  logic [$clog2(LINES)-1:0] flush_line,
  output logic                  ready,
  output logic                  done,
  output logic [W-1:0]          rdata,
  output logic                  cache_we,
  output logic [((SLOTS>1)?$clog2(SLOTS):1)-1:0] cache_slot,
  output logic [1:0]            cache_word,
  output logic [W-1:0]          cache_wdata,
  input  logic [W-1:0]          cache_rdata,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [$clog2(LINES)-1:0] mem_line,
  output logic [1:0]            mem_word,
  output logic [W-1:0]          mem_wdata,
  input  logic [W-1:0]          mem_rdata,
  input  logic                  mem_ack,
  input  logic                  inj_en,
  input  logic [$clog2(LINES)+1:0] inj_addr,
  input  logic [$clog2(W)-1:0]  inj_bit,
  output logic [CNT_W-1:0]      rec_cache_cnt,
  output logic [CNT_W-1:0]      rec_mem_cnt
);
  localparam int LW = $clog2(LINES);
  localparam int AW = LW + 2;
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int NW = LINES * 4;

  typedef enum logic [2:0] {S_IDLE, S_CHK, S_RSTC, S_RSTM, S_COPY, S_WT, S_FLUSH} st_t;
  st_t state;

  logic [W:0]       arr [NW];
  logic [LINES-1:0] dirty;
  logic [SW-1:0]    ptr [LINES];
  logic [SLOTS-1:0] taken;

  logic          op_we, op_fl;
  logic [LW-1:0] a_line;
  logic [1:0]    a_word, wcnt;
  logic [W-1:0]  a_data;

  logic          line_err, have_free;
  logic [SW-1:0] free_idx;
  logic [AW-1:0] w_addr;

  assign w_addr = {a_line, wcnt};

  always_comb begin
    line_err = 1'b0;
    for (int i = 0; i < 4; i++) line_err |= ^arr[{a_line, 2'(i)}];
  end

  always_comb begin
    have_free = 1'b0;
    free_idx  = '0;
    for (int s = SLOTS - 1; s >= 0; s--)
      if (!taken[s]) begin
        have_free = 1'b1;
        free_idx  = SW'(s);
      end
  end

  assign ready       = (state == S_IDLE);
  assign cache_slot  = ptr[a_line];
  assign cache_word  = (state == S_CHK) ? a_word : wcnt;
  assign cache_wdata = (state == S_CHK) ? a_data : arr[w_addr][W-1:0];
  assign cache_we    = (state == S_COPY) ||
                       (state == S_CHK && !line_err && !op_fl && op_we && dirty[a_line]);
  assign mem_req     = (state == S_RSTM) || (state == S_WT) || (state == S_FLUSH);
  assign mem_we      = (state == S_WT) || (state == S_FLUSH);
  assign mem_line    = a_line;
  assign mem_word    = (state == S_WT) ? a_word : wcnt;
  assign mem_wdata   = (state == S_WT) ? a_data : arr[w_addr][W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= S_IDLE;
      done          <= 1'b0;
      rdata         <= '0;
      dirty         <= '0;
      taken         <= '0;
      op_we         <= 1'b0;
      op_fl         <= 1'b0;
      a_line        <= '0;
      a_word        <= '0;
      a_data        <= '0;
      wcnt          <= '0;
      rec_cache_cnt <= '0;
      rec_mem_cnt   <= '0;
      for (int i = 0; i < NW; i++) arr[i] <= '0;
      for (int l = 0; l < LINES; l++) ptr[l] <= '0;
    end else begin
      done <= 1'b0;
      if (inj_en) arr[inj_addr][inj_bit] <= ~arr[inj_addr][inj_bit];
      case (state)
        S_IDLE: begin
          wcnt <= '0;
          if (req) begin
            op_we  <= req_we;
            op_fl  <= 1'b0;
            a_line <= req_addr[AW-1:2];
            a_word <= req_addr[1:0];
            a_data <= req_wdata;
            state  <= S_CHK;
          end else if (flush_req) begin
            op_we  <= 1'b0;
            op_fl  <= 1'b1;
            a_line <= flush_line;
            state  <= S_CHK;
          end
        end
        S_CHK: begin
          wcnt <= '0;
          if (line_err) begin
            state <= dirty[a_line] ? S_RSTC : S_RSTM;
          end else if (op_fl) begin
            if (dirty[a_line]) state <= S_FLUSH;
            else begin
              done  <= 1'b1;
              state <= S_IDLE;
            end
          end else if (!op_we) begin
            rdata <= arr[{a_line, a_word}][W-1:0];
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            arr[{a_line, a_word}] <= {^a_data, a_data};
            if (dirty[a_line]) begin
              done  <= 1'b1;
              state <= S_IDLE;
            end else if (have_free) begin
              taken[free_idx] <= 1'b1;
              dirty[a_line]   <= 1'b1;
              ptr[a_line]     <= free_idx;
              state           <= S_COPY;
            end else begin
              state <= S_WT;
            end
          end
        end
        S_RSTC: begin
          arr[w_addr] <= {^cache_rdata, cache_rdata};
          wcnt <= wcnt + 2'd1;
          if (wcnt == 2'd3) begin
            rec_cache_cnt <= rec_cache_cnt + 1'b1;
            state         <= S_CHK;
          end
        end
        S_RSTM: if (mem_ack) begin
          arr[w_addr] <= {^mem_rdata, mem_rdata};
          wcnt <= wcnt + 2'd1;
          if (wcnt == 2'd3) begin
            rec_mem_cnt <= rec_mem_cnt + 1'b1;
            state       <= S_CHK;
          end
        end
        S_COPY: begin
          wcnt <= wcnt + 2'd1;
          if (wcnt == 2'd3) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end
        end
        S_WT: if (mem_ack) begin
          done  <= 1'b1;
          state <= S_IDLE;
        end
        S_FLUSH: if (mem_ack) begin
          wcnt <= wcnt + 2'd1;
          if (wcnt == 2'd3) begin
            dirty[a_line]      <= 1'b0;
            taken[ptr[a_line]] <= 1'b0;
            done               <= 1'b1;
            state              <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spm_guard_chk.sv
module spm_guard_chk #(
  parameter int LW    = 4,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req,
  input logic             ready,
  input logic             done,
  input logic             cache_we,
  input logic             mem_req,
  input logic             mem_we,
  input logic             mem_ack,
  input logic [LW-1:0]    mem_line,
  input logic [1:0]       mem_word,
  input logic [CNT_W-1:0] rec_cache_cnt,
  input logic [CNT_W-1:0] rec_mem_cnt
);
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ready) |=> !ready);

  p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_line) && $stable(mem_word)));

  p_one_backup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cache_we && mem_req));

  p_cache_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_cache_cnt != $past(rec_cache_cnt)) |-> (rec_cache_cnt == $past(rec_cache_cnt) + 1'b1));

  p_mem_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_mem_cnt != $past(rec_mem_cnt)) |-> (rec_mem_cnt == $past(rec_mem_cnt) + 1'b1));

  p_single_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !((rec_cache_cnt != $past(rec_cache_cnt)) && (rec_mem_cnt != $past(rec_mem_cnt))));
endmodule

bind spm_guard spm_guard_chk #(.LW(LW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .ready(ready), .done(done),
  .cache_we(cache_we), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_line(mem_line), .mem_word(mem_word),
  .rec_cache_cnt(rec_cache_cnt), .rec_mem_cnt(rec_mem_cnt)
);

// File: tb/spm_guard_tb.sv
module spm_guard_tb;
  localparam int LINES = 4, W = 16, SLOTS = 2, CNT_W = 8;
  localparam int LW = 2, AW = 4, SW = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req = 0, req_we = 0, flush_req = 0, inj_en = 0, mem_ack = 0;
  logic [AW-1:0] req_addr = '0, inj_addr = '0;
  logic [W-1:0]  req_wdata = '0;
  logic [LW-1:0] flush_line = '0;
  logic [3:0]    inj_bit = '0;
  logic ready, done, cache_we, mem_req, mem_we;
  logic [W-1:0] rdata, cache_wdata, cache_rdata, mem_wdata, mem_rdata;
  logic [SW-1:0] cache_slot;
  logic [1:0] cache_word, mem_word;
  logic [LW-1:0] mem_line;
  logic [CNT_W-1:0] rec_cache_cnt, rec_mem_cnt;

  spm_guard #(.LINES(LINES), .W(W), .SLOTS(SLOTS), .CNT_W(CNT_W)) u_dut (
    .clk, .rst_n, .req, .req_we, .req_addr, .req_wdata, .flush_req, .flush_line,
    .ready, .done, .rdata, .cache_we, .cache_slot, .cache_word, .cache_wdata,
    .cache_rdata, .mem_req, .mem_we, .mem_line, .mem_word, .mem_wdata, .mem_rdata,
    .mem_ack, .inj_en, .inj_addr, .inj_bit, .rec_cache_cnt, .rec_mem_cnt);

  logic [W-1:0] cache_m [SLOTS*4];
  logic [W-1:0] mem_m [LINES*4];
  logic [W-1:0] ref_m [LINES*4];
  int mem_writes = 0;
  int vectors = 0, errs = 0;
  bit finished = 0;

  assign cache_rdata = cache_m[{cache_slot, cache_word}];
  assign mem_rdata   = mem_m[{mem_line, mem_word}];

  initial begin
    for (int i = 0; i < SLOTS*4; i++) cache_m[i] = '0;
    for (int i = 0; i < LINES*4; i++) begin mem_m[i] = '0; ref_m[i] = '0; end
  end

  always @(posedge clk) begin
    if (cache_we) cache_m[{cache_slot, cache_word}] <= cache_wdata;
    mem_ack <= mem_req && !mem_ack;
    if (mem_req && mem_ack && mem_we) begin
      mem_m[{mem_line, mem_word}] <= mem_wdata;
      mem_writes <= mem_writes + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  bit    q_rd[$];
  logic [W-1:0] q_d[$];
  string q_tag[$];

  always @(negedge clk) if (rst_n && done) begin
    if (q_rd.size() == 0) chk("R2 unexpected done", 1, 0);
    else begin
      bit r; logic [W-1:0] d; string t;
      r = q_rd.pop_front(); d = q_d.pop_front(); t = q_tag.pop_front();
      if (r) chk(t, rdata, d);
    end
  end

  task automatic op(input bit we, input bit fl, input logic [AW-1:0] a,
                    input logic [W-1:0] d, input string tag);
    @(negedge clk);
    while (!ready) @(negedge clk);
    q_rd.push_back(!we && !fl); q_d.push_back(ref_m[a]); q_tag.push_back(tag);
    if (fl) begin flush_req = 1; flush_line = a[AW-1:2]; end
    else begin req = 1; req_we = we; req_addr = a; req_wdata = d; end
    @(negedge clk);
    req = 0; flush_req = 0;
    if (we && !fl) ref_m[a] = d;
    while (!done) @(negedge clk);
  endtask

  task automatic inject(input logic [AW-1:0] a, input logic [3:0] b);
    @(negedge clk);
    inj_en = 1; inj_addr = a; inj_bit = b;
    @(negedge clk);
    inj_en = 0;
  endtask

  task automatic chk_slot(input int s, input int line, input string tag);
    for (int w = 0; w < 4; w++) chk(tag, cache_m[s*4+w], ref_m[line*4+w]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready", ready, 1);
    chk("R1 done", done, 0);
    chk("R1 rec_cache", rec_cache_cnt, 0);
    chk("R1 rec_mem", rec_mem_cnt, 0);

    op(1, 0, 4'h1, 16'hA5A5, "R3 store clean");
    chk_slot(0, 0, "R3 slot0 copy");
    chk("R3 no mem traffic", mem_writes, 0);
    op(1, 0, 4'h2, 16'h1234, "R4 store dirty");
    chk("R4 word in slot", cache_m[2], 16'h1234);
    chk("R4 no mem traffic", mem_writes, 0);
    op(1, 0, 4'h4, 16'h0F0F, "R3 second line");
    chk_slot(1, 1, "R3 slot1 copy");
    op(1, 0, 4'h8, 16'hBEEF, "R5 write-through");
    chk("R5 mem word", mem_m[8], 16'hBEEF);
    chk("R5 mem writes", mem_writes, 1);
    op(0, 0, 4'h1, '0, "R2 load line0 w1");

    inject(4'h1, 4'd3);
    op(0, 0, 4'h1, '0, "R7 load after cache restore");
    chk("R7 rec_cache", rec_cache_cnt, 1);
    chk("R7 rec_mem unchanged", rec_mem_cnt, 0);

    inject(4'h8, 4'd15);
    op(0, 0, 4'h8, '0, "R8 load after mem restore");
    chk("R8 rec_mem", rec_mem_cnt, 1);

    inject(4'hF, 4'd0);
    op(0, 0, 4'hC, '0, "R6 neighbour error load");
    chk("R6 rec_mem", rec_mem_cnt, 2);
    op(0, 0, 4'hF, '0, "R6 restored neighbour");
    chk("R6 no extra restore", rec_mem_cnt, 2);

    op(0, 1, 4'h8, '0, "R10 flush clean");
    chk("R10 no mem traffic", mem_writes, 1);
    chk("R5 line stays clean", mem_writes, 1);

    op(0, 1, 4'h0, '0, "R9 flush dirty");
    chk("R9 mem writes", mem_writes, 5);
    for (int w = 0; w < 4; w++) chk("R9 mem line0", mem_m[w], ref_m[w]);
    op(1, 0, 4'hE, 16'h7777, "R9 slot reuse store");
    chk_slot(0, 3, "R9 slot0 reused by line3");

    inject(4'h4, 4'd5);
    op(1, 0, 4'h7, 16'hCAFE, "R12 store after restore");
    chk("R12 rec_cache", rec_cache_cnt, 2);
    chk("R12 slot word", cache_m[7], 16'hCAFE);
    op(0, 0, 4'h4, '0, "R12 restored word");
    op(0, 0, 4'h7, '0, "R12 stored word");

    op(0, 0, 4'h2, '0, "R2 load after flush");
    op(1, 0, 4'h0, 16'h0001, "R5 pool full store");
    chk("R5 mem word line0", mem_m[0], 16'h0001);
    chk("R5 mem writes after", mem_writes, 6);

    repeat (3) @(negedge clk);
    chk("R2 queue drained", q_rd.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      vectors++; errs++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end
endmodule